// File: doc/BRIEF.md
# Disk Device Status and Interrupt Controller

This block owns the host-visible status byte, the error byte and the interrupt request line of a parallel ATA style storage device. A command engine beside it reports what happens through single-cycle event strobes: command register written, data transfer wanted, data block moved, command finished (with or without an error code), write fault, spindle ready, heads settled, reset processing finished and power-on diagnostic result. The block turns those strobes into the busy/data-request handshake the host polls, and into an interrupt the host acknowledges by reading status.

A small state machine carries the handshake. Its states are `ST_RESET` (busy during power-on, hard reset or soft reset), `ST_IDLE` (ready for a command), `ST_EXEC` (busy executing) and `ST_XFER` (data request raised, not busy). The transitions are: any state to `ST_RESET` on the hard reset strobe or while soft reset is held; `ST_RESET` to `ST_IDLE` when reset processing reports done or the reset timeout runs out; `ST_IDLE` to `ST_EXEC` on a command write; `ST_EXEC` to `ST_IDLE` on completion; `ST_EXEC` to `ST_XFER` on a transfer request; `ST_XFER` to `ST_EXEC` when a data block has been moved. On a two-device cable, device 0 reports its own diagnostic code with bit 7 set when device 1 failed, and passes device 1's own code through when the host selects device 1.

Top module: `ata_status_ctrl`

## Requirements
- R1: The status byte is {BSY[7], DRDY[6], DF[5], DSC[4], DRQ[3], 0[2], 0[1], ERR[0]}; the error byte is {ICRC[7], UNC[6], 0[5], IDNF[4], 0[3], ABRT[2], TK0NF[1], AMNF[0]}, with bits 5 and 3 always 0 even when the reported code has them set.
- R2: After rst_n is released the machine is in `ST_RESET`: BSY=1, DRQ=0, DRDY=0, DSC=0, DF=0, ERR=0, intrq_o=0.
- R3: One cycle after a hard reset strobe, or while soft reset is held, BSY=1 and DRQ=0; busy stays until the cycle after reset_done_i is seen with soft reset released.
- R4: Without reset_done_i, `ST_RESET` exits to `ST_IDLE` after RST_TIMEOUT clock edges counted from the edge that entered it.
- R5: A command write in `ST_IDLE` sets BSY on the next cycle and clears DF and ERR; a command write while BSY or DRQ is 1 leaves status unchanged.
- R6: A transfer request in `ST_EXEC` gives DRQ=1, BSY=0 on the next cycle; a block-done strobe in `ST_XFER` gives BSY=1, DRQ=0; BSY and DRQ are never both 1.
- R7: A completion strobe in `ST_EXEC` clears BSY on the next cycle; with err_valid_i it sets ERR and loads the error byte, otherwise ERR stays 0.
- R8: intrq_o rises one cycle after a completion or after entering `ST_XFER`, only when int_en_i is 1 at that strobe.
- R9: A status read with no new interrupt event drops intrq_o on the next cycle.
- R10: DF sets one cycle after fault_i and holds until a command is accepted or a reset begins.
- R11: DRDY and DSC are 0 after rst_n, set one cycle after spin_ready_i and seek_done_i respectively, and then stay 1 through hard and soft resets.
- R12: A diagnostic load makes the error byte {peer_fail_i, 0000, diag_code_i[2:0]} (0x01 pass, 0x02-0x06 faults, 0x80 added for a failed device 1); with dev_sel_i=1 error_o shows peer_code_i instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| host_reset_i | input | 1 | Hard reset strobe from the cable |
| srst_i | input | 1 | Soft reset level from the control register |
| cmd_wr_i | input | 1 | Command register written |
| xfer_req_i | input | 1 | Engine wants a data block moved |
| blk_done_i | input | 1 | A data block has been moved |
| cmd_done_i | input | 1 | Command finished |
| err_valid_i | input | 1 | Qualifies cmd_done_i as failed |
| err_code_i | input | 8 | Error bits reported with a failed completion |
| fault_i | input | 1 | Write fault event |
| spin_ready_i | input | 1 | Spindle at speed |
| seek_done_i | input | 1 | Heads settled after spin-up |
| reset_done_i | input | 1 | Reset processing finished |
| diag_load_i | input | 1 | Load power-on diagnostic result |
| diag_code_i | input | 3 | Own diagnostic code |
| peer_fail_i | input | 1 | Device 1 reported failure |
| dev_sel_i | input | 1 | Host selected device 1 |
| peer_code_i | input | 8 | Device 1's own diagnostic code |
| status_rd_i | input | 1 | Host read the status register |
| int_en_i | input | 1 | Interrupt enable |
| status_o | output | 8 | Status byte |
| error_o | output | 8 | Error byte |
| intrq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that BSY and DRQ never coexist, that a command write in idle raises busy, that the reset timeout forces the exit, that a status read clears a pending interrupt, that DF and DRDY hold, and that the unused error bits stay clear. Only the bench's scenarios show the full sequences: a multi-block command walking through execute, transfer and back, the error byte captured at a failed completion, interrupts withheld when disabled, command writes ignored while busy, and the diagnostic merge with and without a device 1 failure and with device 1 selected.

// File: rtl/atastat_pkg.sv
package atastat_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_XFER  = 2'd3
    } hs_state_t;

    localparam logic [7:0] ERR_USED_MASK = 8'hD7;
endpackage

// File: rtl/atastat_fsm.sv
module atastat_fsm
    import atastat_pkg::*;
#(
    parameter int RST_TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_reset_i,
    input  logic srst_i,
    input  logic reset_done_i,
    input  logic cmd_wr_i,
    input  logic xfer_req_i,
    input  logic blk_done_i,
    input  logic cmd_done_i,
    output logic bsy_o,
    output logic drq_o,
    output logic rst_ev_o,
    output logic cmd_acc_o,
    output logic done_ev_o,
    output logic drq_ev_o
);
    localparam int CW = $clog2(RST_TIMEOUT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_TIMEOUT - 1);

    hs_state_t st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic rst_ev;

    assign rst_ev = host_reset_i | srst_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RESET;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (rst_ev || st_q != ST_RESET) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst_ev) begin
            st_d = ST_RESET;
        end else begin
            unique case (st_q)
                ST_RESET: if (reset_done_i || cnt_q == CNT_LAST) st_d = ST_IDLE;
                ST_IDLE:  if (cmd_wr_i)   st_d = ST_EXEC;
                ST_EXEC:  if (cmd_done_i) st_d = ST_IDLE;
                          else if (xfer_req_i) st_d = ST_XFER;
                ST_XFER:  if (blk_done_i) st_d = ST_EXEC;
                default:  st_d = ST_RESET;
            endcase
        end
    end

    always_comb begin
        bsy_o     = 1'b0;
        drq_o     = 1'b0;
        cmd_acc_o = 1'b0;
        done_ev_o = 1'b0;
        drq_ev_o  = 1'b0;
        rst_ev_o  = rst_ev;
        unique case (st_q)
            ST_RESET: bsy_o = 1'b1;
            ST_IDLE:  cmd_acc_o = cmd_wr_i & ~rst_ev;
            ST_EXEC: begin
                bsy_o     = 1'b1;
                done_ev_o = cmd_done_i & ~rst_ev;
                drq_ev_o  = xfer_req_i & ~cmd_done_i & ~rst_ev;
            end
            ST_XFER:  drq_o = 1'b1;
            default:  bsy_o = 1'b1;
        endcase
    end

    assert_cmd_sets_bsy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cmd_wr_i && !rst_ev) |=> (st_q == ST_EXEC));

    assert_rst_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESET && !rst_ev && cnt_q == CNT_LAST) |=> (st_q == ST_IDLE));

    assert_rst_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ev |=> (st_q == ST_RESET));
endmodule

// File: rtl/atastat_flags.sv
module atastat_flags
    import atastat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_ev_i,
    input  logic       cmd_acc_i,
    input  logic       done_ev_i,
    input  logic       err_valid_i,
    input  logic [7:0] err_code_i,
    input  logic       fault_i,
    input  logic       spin_ready_i,
    input  logic       seek_done_i,
    input  logic       diag_load_i,
    input  logic [2:0] diag_code_i,
    input  logic       peer_fail_i,
    output logic       drdy_o,
    output logic       dsc_o,
    output logic       df_o,
    output logic       err_o,
    output logic [7:0] err_reg_o
);
    logic drdy_q, dsc_q, df_q, err_q;
    logic [7:0] ereg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
            dsc_q  <= 1'b0;
            df_q   <= 1'b0;
            err_q  <= 1'b0;
            ereg_q <= 8'h00;
        end else begin
            if (spin_ready_i) drdy_q <= 1'b1;
            if (seek_done_i)  dsc_q  <= 1'b1;

            if (fault_i)                      df_q <= 1'b1;
            else if (cmd_acc_i || rst_ev_i)   df_q <= 1'b0;

            if (cmd_acc_i || rst_ev_i)        err_q <= 1'b0;
            else if (done_ev_i && err_valid_i) err_q <= 1'b1;

            if (diag_load_i)
                ereg_q <= {peer_fail_i, 4'b0000, diag_code_i};
            else if (done_ev_i && err_valid_i)
                ereg_q <= err_code_i & ERR_USED_MASK;
        end
    end

    assign drdy_o    = drdy_q;
    assign dsc_o     = dsc_q;
    assign df_o      = df_q;
    assign err_o     = err_q;
    assign err_reg_o = ereg_q;

    assert_df_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (df_q && !cmd_acc_i && !rst_ev_i) |=> df_q);

    assert_drdy_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_q |=> drdy_q);

    assert_err_unused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ereg_q[5] == 1'b0 && ereg_q[3] == 1'b0));
endmodule

// File: rtl/atastat_irq.sv
module atastat_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic int_en_i,
    input  logic done_ev_i,
    input  logic drq_ev_i,
    input  logic rst_ev_i,
    input  logic status_rd_i,
    output logic intrq_o
);
    logic pend_q, set_ev;

    assign set_ev = int_en_i & (done_ev_i | drq_ev_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pend_q <= 1'b0;
        else if (set_ev)                   pend_q <= 1'b1;
        else if (status_rd_i || rst_ev_i)  pend_q <= 1'b0;
    end

    assign intrq_o = pend_q;

    assert_rd_clears_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !done_ev_i && !drq_ev_i) |=> !pend_q);

    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !int_en_i) |=> !pend_q);
endmodule

// File: rtl/ata_status_ctrl.sv
module ata_status_ctrl #(
    parameter int RST_TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_reset_i,
    input  logic       srst_i,
    input  logic       cmd_wr_i,
    input  logic       xfer_req_i,
    input  logic       blk_done_i,
    input  logic       cmd_done_i,
    input  logic       err_valid_i,
    input  logic [7:0] err_code_i,
    input  logic       fault_i,
    input  logic       spin_ready_i,
    input  logic       seek_done_i,
    input  logic       reset_done_i,
    input  logic       diag_load_i,
    input  logic [2:0] diag_code_i,
    input  logic       peer_fail_i,
    input  logic       dev_sel_i,
    input  logic [7:0] peer_code_i,
    input  logic       status_rd_i,
    input  logic       int_en_i,
    output logic [7:0] status_o,
    output logic [7:0] error_o,
    output logic       intrq_o
);
    logic bsy, drq, rst_ev, cmd_acc, done_ev, drq_ev;
    logic drdy, dsc, df, err;
    logic [7:0] ereg;

    atastat_fsm #(.RST_TIMEOUT(RST_TIMEOUT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .host_reset_i(host_reset_i), .srst_i(srst_i),
        .reset_done_i(reset_done_i), .cmd_wr_i(cmd_wr_i), .xfer_req_i(xfer_req_i),
        .blk_done_i(blk_done_i), .cmd_done_i(cmd_done_i), .bsy_o(bsy), .drq_o(drq),
        .rst_ev_o(rst_ev), .cmd_acc_o(cmd_acc), .done_ev_o(done_ev), .drq_ev_o(drq_ev)
    );

    atastat_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rst_ev_i(rst_ev), .cmd_acc_i(cmd_acc),
        .done_ev_i(done_ev), .err_valid_i(err_valid_i), .err_code_i(err_code_i),
        .fault_i(fault_i), .spin_ready_i(spin_ready_i), .seek_done_i(seek_done_i),
        .diag_load_i(diag_load_i), .diag_code_i(diag_code_i), .peer_fail_i(peer_fail_i),
        .drdy_o(drdy), .dsc_o(dsc), .df_o(df), .err_o(err), .err_reg_o(ereg)
    );

    atastat_irq u_irq (
        .clk(clk), .rst_n(rst_n), .int_en_i(int_en_i), .done_ev_i(done_ev),
        .drq_ev_i(drq_ev), .rst_ev_i(rst_ev), .status_rd_i(status_rd_i),
        .intrq_o(intrq_o)
    );

    assign status_o = {bsy, drdy, df, dsc, drq, 1'b0, 1'b0, err};
    assign error_o  = dev_sel_i ? peer_code_i : ereg;

    assert_bsy_drq_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[7] && status_o[3]));

    assert_fixed_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:1] == 2'b00));
endmodule

// File: tb/test_ata_status_ctrl.sv
module test_ata_status_ctrl;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_reset_i = 0, srst_i = 0, cmd_wr_i = 0, xfer_req_i = 0, blk_done_i = 0;
    logic cmd_done_i = 0, err_valid_i = 0, fault_i = 0, spin_ready_i = 0, seek_done_i = 0;
    logic reset_done_i = 0, diag_load_i = 0, peer_fail_i = 0, dev_sel_i = 0;
    logic status_rd_i = 0, int_en_i = 0;
    logic [7:0] err_code_i = 8'h00, peer_code_i = 8'h00;
    logic [2:0] diag_code_i = 3'd0;
    logic [7:0] status_o, error_o;
    logic intrq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ata_status_ctrl #(.RST_TIMEOUT(TMO)) i_ata_status_ctrl (
        .clk(clk), .rst_n(rst_n), .host_reset_i(host_reset_i), .srst_i(srst_i),
        .cmd_wr_i(cmd_wr_i), .xfer_req_i(xfer_req_i), .blk_done_i(blk_done_i),
        .cmd_done_i(cmd_done_i), .err_valid_i(err_valid_i), .err_code_i(err_code_i),
        .fault_i(fault_i), .spin_ready_i(spin_ready_i), .seek_done_i(seek_done_i),
        .reset_done_i(reset_done_i), .diag_load_i(diag_load_i), .diag_code_i(diag_code_i),
        .peer_fail_i(peer_fail_i), .dev_sel_i(dev_sel_i), .peer_code_i(peer_code_i),
        .status_rd_i(status_rd_i), .int_en_i(int_en_i),
        .status_o(status_o), .error_o(error_o), .intrq_o(intrq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one-cycle strobe helpers: drive at negedge, release at the next negedge
    task automatic clear_strobes();
        host_reset_i = 0; cmd_wr_i = 0; xfer_req_i = 0; blk_done_i = 0; cmd_done_i = 0;
        err_valid_i = 0; fault_i = 0; spin_ready_i = 0; seek_done_i = 0;
        reset_done_i = 0; diag_load_i = 0; status_rd_i = 0;
    endtask

    task automatic pulse_cmd();  cmd_wr_i = 1; tick(); clear_strobes(); endtask
    task automatic pulse_rdone(); reset_done_i = 1; tick(); clear_strobes(); endtask

    task automatic t_power_on();
        rst_n = 0; tick(); rst_n = 1; tick();
        chk("R2 status after power-on", status_o, 8'h80);
        chk("R2 intrq after power-on", {7'd0, intrq_o}, 8'h00);
        pulse_rdone();
        chk("R3 reset done leaves busy", status_o, 8'h00);
        spin_ready_i = 1; seek_done_i = 1; tick(); clear_strobes();
        chk("R11 DRDY and DSC set", status_o, 8'h50);
    endtask

    task automatic t_soft_reset();
        srst_i = 1; tick();
        chk("R3 soft reset busy", status_o, 8'hD0);
        reset_done_i = 1; tick(); clear_strobes();
        chk("R3 busy held while soft reset", status_o, 8'hD0);
        srst_i = 0; tick();
        pulse_rdone();
        chk("R3 soft reset released and done", status_o, 8'h50);
        chk("R11 DRDY DSC survive soft reset", {6'd0, status_o[6], status_o[4]}, 8'h03);
    endtask

    task automatic t_timeout();
        host_reset_i = 1; tick(); clear_strobes();
        chk("R3 hard reset busy", status_o, 8'hD0);
        repeat (TMO - 1) tick();
        chk("R4 still busy before timeout", status_o, 8'hD0);
        tick();
        chk("R4 timeout exits reset", status_o, 8'h50);
    endtask

    task automatic t_multi_block();
        int_en_i = 1;
        pulse_cmd();
        chk("R5 command sets busy", status_o, 8'hD0);
        pulse_cmd();
        chk("R5 command while busy ignored", status_o, 8'hD0);
        xfer_req_i = 1; tick(); clear_strobes();
        chk("R6 DRQ without BSY", status_o, 8'h58);
        chk("R8 intrq on data ready", {7'd0, intrq_o}, 8'h01);
        status_rd_i = 1; tick(); clear_strobes();
        chk("R9 status read clears intrq", {7'd0, intrq_o}, 8'h00);
        pulse_cmd();
        chk("R5 command during DRQ ignored", status_o, 8'h58);
        blk_done_i = 1; tick(); clear_strobes();
        chk("R6 block done busy again", status_o, 8'hD0);
        cmd_done_i = 1; tick(); clear_strobes();
        chk("R7 completion clears busy", status_o, 8'h50);
        chk("R8 intrq on completion", {7'd0, intrq_o}, 8'h01);
        status_rd_i = 1; tick(); clear_strobes();
        chk("R9 read clears completion intrq", {7'd0, intrq_o}, 8'h00);
    endtask

    task automatic t_error_and_irq_off();
        int_en_i = 0;
        pulse_cmd();
        cmd_done_i = 1; err_valid_i = 1; err_code_i = 8'hFF; tick(); clear_strobes();
        chk("R7 failed completion sets ERR", status_o, 8'h51);
        chk("R1 error byte unused bits clear", error_o, 8'hD7);
        chk("R8 no intrq when disabled", {7'd0, intrq_o}, 8'h00);
        pulse_cmd();
        chk("R5 command clears ERR", status_o, 8'hD0);
        err_code_i = 8'h04; cmd_done_i = 1; err_valid_i = 1; tick(); clear_strobes();
        chk("R1 abort code position", error_o, 8'h04);
    endtask

    task automatic t_fault();
        pulse_cmd();
        fault_i = 1; tick(); clear_strobes();
        chk("R10 DF sets", status_o, 8'hF0);
        cmd_done_i = 1; tick(); clear_strobes();
        chk("R10 DF held past completion", status_o, 8'h70);
        pulse_cmd();
        chk("R10 DF cleared by next command", status_o, 8'hD0);
        fault_i = 1; tick(); clear_strobes();
        host_reset_i = 1; tick(); clear_strobes();
        chk("R10 DF cleared by reset", status_o[5] ? 8'h01 : 8'h00, 8'h00);
        pulse_rdone();
    endtask

    task automatic t_diag();
        diag_load_i = 1; diag_code_i = 3'd1; peer_fail_i = 0; tick(); clear_strobes();
        chk("R12 pass code", error_o, 8'h01);
        diag_load_i = 1; diag_code_i = 3'd3; peer_fail_i = 1; tick(); clear_strobes();
        chk("R12 device 1 failure merged", error_o, 8'h83);
        dev_sel_i = 1; peer_code_i = 8'h05; tick();
        chk("R12 device 1 code when selected", error_o, 8'h05);
        dev_sel_i = 0; tick();
        chk("R12 own code when deselected", error_o, 8'h83);
    endtask

    initial begin
        tick();
        t_power_on();
        t_soft_reset();
        t_timeout();
        t_multi_block();
        t_error_and_irq_off();
        t_fault();
        t_diag();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule